// File: doc/BRIEF.md
# Flash Whole-Array Erase Sequencer

This block runs on the host side of a byte-wide, chip-erasable flash and carries out the complete erase procedure without software help. After a start pulse it asks a separate program engine to fill every byte with 00h. Filling the array first makes all cells start from the same state, so the erase acts on them evenly. The sequencer then gives an erase pulse and checks the array one byte at a time. When a byte does not yet read FFh, it gives another erase pulse and continues checking from that same byte instead of starting over.

All flash traffic goes through a single bus-request port. The port carries a request, a write/read flag, an address and write data. The far side answers with a one-cycle done and, for reads, the read data. Every wait is counted in clock cycles and set by a parameter. The number of erase pulses is counted across the whole array. When that count reaches the limit while a byte still fails, the run stops and reports fail. When the last byte checks clean, the sequencer writes the read-mode command and reports pass.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, pass, fail, prog_start and bus_req are all low.
- R2: An accepted start gives exactly one prog_start pulse. No bus access is made until prog_done has been seen.
- R3: An erase pulse is two bus writes of 20h in a row. The next bus access comes no sooner than ERASE_WAIT cycles after the second of these writes completes.
- R4: Each byte check is a write of A0h carrying that byte's address. At least VERIFY_WAIT cycles later comes a read of the same address, and the byte passes only if the read returns FFh.
- R5: Checking starts at address 0 and moves up one address at a time to the last address, 2^ADDR_W-1.
- R6: When a check fails, the next bus access starts a new erase pulse. Checking then resumes at the failing address.
- R7: Erase pulses are counted across the whole array, starting from 1 for the first pulse. A failed check when the count already equals MAX_ERASES ends the run with fail. The total number of pulses never exceeds MAX_ERASES.
- R8: When the last address reads FFh, a write of 00h is issued, and pass is raised after it completes.
- R9: busy is high from the accepted start until pass or fail is raised. A start that arrives while busy is high is ignored.
- R10: pass or fail stays high until the next accepted start clears it. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase run (taken only when idle) |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run erased the whole array |
| fail | output | 1 | Last run hit the erase-pulse limit |
| prog_start | output | 1 | One-cycle request to the program engine to fill the array with 00h |
| prog_done | input | 1 | Program engine finished filling the array |
| bus_req | output | 1 | Bus access requested, held until bus_done |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8 | Command or data byte for writes |
| bus_rdata | input | 8 | Read data, valid with bus_done |
| bus_done | input | 1 | One-cycle completion of the current access |

## Verification
The hardest case to reach is a check that fails partway up the array and so forces an extra erase pulse and a resume at a non-zero address. A variant of that case is the erase limit being reached on the last pulse. The bench's flash model gives each byte a random number of erase pulses it needs before it reads FFh. This puts failures at scattered addresses and produces runs that need exactly MAX_ERASES pulses or one more than that. The bench then compares the pulse count, the read count, the order of checked addresses and the outcome with a reference loop kept in the bench.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W      = 17,
  parameter int ERASE_WAIT  = 1000000,
  parameter int VERIFY_WAIT = 600,
  parameter int MAX_ERASES  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic              prog_start,
  input  logic              prog_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_done
);

  localparam int MAXW = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int WW   = $clog2(MAXW + 1);
  localparam int CW   = $clog2(MAX_ERASES + 1);
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_PSTART, S_PWAIT, S_ER1, S_ER2, S_EWAIT,
    S_VSET, S_VWAIT, S_VREAD, S_RDCMD
  } st_t;

  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     ecnt;
  logic [WW-1:0]     wcnt;

  wire last_addr = (addr_q == {ADDR_W{1'b1}});
  wire byte_ok   = (bus_rdata == 8'hFF);

  assign busy       = (state != S_IDLE);
  assign prog_start = (state == S_PSTART);
  assign bus_req    = (state == S_ER1) || (state == S_ER2) || (state == S_VSET) ||
                      (state == S_VREAD) || (state == S_RDCMD);
  assign bus_we     = (state != S_VREAD);
  assign bus_addr   = ((state == S_VSET) || (state == S_VREAD)) ? addr_q : '0;

  always_comb begin
    case (state)
      S_ER1, S_ER2: bus_wdata = CMD_ERASE;
      S_VSET:       bus_wdata = CMD_VERIFY;
      default:      bus_wdata = CMD_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      ecnt   <= '0;
      wcnt   <= '0;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pass   <= 1'b0;
          fail   <= 1'b0;
          addr_q <= '0;
          ecnt   <= '0;
          state  <= S_PSTART;
        end
        S_PSTART: state <= S_PWAIT;
        S_PWAIT: if (prog_done) begin
          ecnt  <= CW'(1);
          state <= S_ER1;
        end
        S_ER1: if (bus_done) state <= S_ER2;
        S_ER2: if (bus_done) begin
          wcnt  <= '0;
          state <= S_EWAIT;
        end
        S_EWAIT: begin
          if (wcnt == WW'(ERASE_WAIT - 1)) begin
            wcnt  <= '0;
            state <= S_VSET;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_VSET: if (bus_done) begin
          wcnt  <= '0;
          state <= S_VWAIT;
        end
        S_VWAIT: begin
          if (wcnt == WW'(VERIFY_WAIT - 1)) begin
            wcnt  <= '0;
            state <= S_VREAD;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_VREAD: if (bus_done) begin
          if (byte_ok) begin
            if (last_addr) begin
              state <= S_RDCMD;
            end else begin
              addr_q <= addr_q + 1'b1;
              state  <= S_VSET;
            end
          end else if (ecnt == CW'(MAX_ERASES)) begin
            fail  <= 1'b1;
            state <= S_IDLE;
          end else begin
            ecnt  <= ecnt + 1'b1;
            state <= S_ER1;
          end
        end
        S_RDCMD: if (bus_done) begin
          pass  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_busy_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(pass || fail));

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt <= CW'(MAX_ERASES));

  p_resume_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_done && !byte_ok) |=> $stable(addr_q));

  p_pass_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(bus_req && bus_we && bus_done && bus_wdata == 8'h00));

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int EW = 20;
  localparam int VW = 5;
  localparam int MX = 6;

  logic clk = 0, rst_n = 0, start = 0, prog_done = 0, bus_done = 0;
  logic [7:0] bus_rdata = 0;
  logic busy, pass, fail, prog_start, bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;

  flash_erase_seq #(.ADDR_W(AW), .ERASE_WAIT(EW), .VERIFY_WAIT(VW), .MAX_ERASES(MX)) u_flash_erase_seq (
    .clk, .rst_n, .start, .busy, .pass, .fail, .prog_start, .prog_done,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_done);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  int need [N];
  int pulses, reads, prog_pulses, pcnt, exp_addr, last_w, pulse_cyc, va, va_cyc;
  bit armed, filled, pulse_pend, want_erase;
  int v2, v3, v4, v5, v6;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (prog_start) begin prog_pulses++; pcnt = 6; end
    prog_done <= (pcnt == 1);
    if (pcnt == 1) filled = 1;
    if (pcnt > 0) pcnt--;
    if (bus_req && !bus_done) begin
      bus_done <= 1;
      if (!filled) v2++;
      if (pulse_pend) begin
        if (cyc - pulse_cyc < EW) v3++;
        pulse_pend = 0;
      end
      if (want_erase) begin
        if (!(bus_we && bus_wdata == 8'h20)) v6++;
        want_erase = 0;
      end
      if (bus_we) begin
        last_w = bus_wdata;
        if (bus_wdata == 8'h20) begin
          if (armed) begin pulses++; armed = 0; pulse_pend = 1; pulse_cyc = cyc; end
          else armed = 1;
        end else begin
          armed = 0;
          if (bus_wdata == 8'hA0) begin va = bus_addr; va_cyc = cyc; end
        end
      end else begin
        armed = 0;
        reads++;
        if (bus_addr != va || cyc - va_cyc < VW) v4++;
        if (bus_addr != exp_addr) v5++;
        if (pulses >= need[bus_addr]) begin
          bus_rdata <= 8'hFF;
          exp_addr = bus_addr + 1;
        end else begin
          bus_rdata <= 8'h00;
          want_erase = 1;
        end
      end
    end else begin
      bus_done <= 0;
    end
  end

  function automatic void model(output bit ok, output int p, output int r);
    int a = 0;
    p = 1; r = 0;
    forever begin
      r++;
      if (p >= need[a]) begin
        if (a == N - 1) begin ok = 1; return; end
        a++;
      end else begin
        if (p == MX) begin ok = 0; return; end
        p++;
      end
    end
  endfunction

  task automatic run(input string tag, input bit poke);
    bit eok; int ep, er, t;
    model(eok, ep, er);
    pulses = 0; reads = 0; prog_pulses = 0; exp_addr = 0; filled = 0; armed = 0;
    pulse_pend = 0; want_erase = 0; v2 = 0; v3 = 0; v4 = 0; v5 = 0; v6 = 0; last_w = -1;
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
    chk(busy && !pass && !fail, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    t = 0;
    while (!(pass || fail) && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, {"R9 run ends ", tag}, t, 0);
    chk(pass == eok && fail == !eok, {"R7 outcome ", tag}, pass, eok);
    chk(!busy, {"R9 idle at end ", tag}, busy, 0);
    chk(pulses == ep, {"R7 pulse count ", tag}, pulses, ep);
    chk(reads == er, {"R6 read count ", tag}, reads, er);
    chk(prog_pulses == 1, {"R2 one fill request ", tag}, prog_pulses, 1);
    chk(v2 == 0, {"R2 no access before fill ", tag}, v2, 0);
    chk(v3 == 0, {"R3 erase wait ", tag}, v3, 0);
    chk(v4 == 0, {"R4 verify address and wait ", tag}, v4, 0);
    chk(v5 == 0, {"R5 R6 check order ", tag}, v5, 0);
    chk(v6 == 0, {"R6 erase after miss ", tag}, v6, 0);
    if (eok) chk(last_w == 8'h00, {"R8 read-mode write ", tag}, last_w, 0);
    repeat (8) @(negedge clk);
    chk(pass == eok && fail == !eok && !busy, {"R10 result held ", tag}, pass, eok);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !pass && !fail && !prog_start && !bus_req, "R1 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) need[i] = 1;
    run("single pulse", 0);
    for (int i = 0; i < N; i++) need[i] = 1;
    need[N-1] = 4;
    run("late miss", 1);
    for (int i = 0; i < N; i++) need[i] = 1;
    need[7] = MX;
    run("exact limit", 0);
    need[7] = MX + 1;
    run("over limit", 0);
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < N; i++) need[i] = 1 + ($urandom % 5);
      run("random", k == 2);
    end
    for (int i = 0; i < N; i++) need[i] = 1 + ($urandom % (MX + 2));
    run("random edge", 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1500000;
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule